// File: doc/BRIEF.md
# Indexed Clock-and-Configuration Byte Store

This block combines a calendar clock with a 128-byte configuration store. Both are reached through two byte-wide ports on a simple host bus. The host first writes a byte number to the select port. A read or write strobe on the value port then moves one byte to or from that location. Most locations are plain storage. Eight of them are live counters that keep seconds, minutes, hours, day, month, year and century in packed BCD, plus a mode byte. The counters advance once per second, counted from a slow timebase strobe.

The timebase arrives as a one-cycle strobe that is already synchronous to `clk`, one strobe per 32.768 kHz period. After `PULSES_PER_SEC` strobes a second elapses. The whole carry chain, from seconds through to century, settles in the clock cycle that follows. Hours count either 00 to 23 or 01 to 12 with a PM flag. A bit in the mode byte picks between the two.

Top module: `clockram`

## Requirements
- R1: After reset, the clock bytes read as follows: seconds 00h (offset 00h), minutes 00h (02h), hours 00h (04h), day 01h (07h), month 01h (08h), year 00h (09h), mode 02h (0Bh) and century 20h (32h). `host_rdata` reads 00h until the first read.
- R2: A write to the select port (`host_port`=0) latches bits 6:0 of `host_wdata` as the byte number and ignores bit 7. A read of the select port returns {0, byte number}.
- R3: A read strobe on the value port (`host_port`=1) presents the addressed byte on `host_rdata` one clock later, and the byte is held until the next read. Every offset other than 00h, 02h, 04h, 07h, 08h, 09h, 0Bh and 32h is plain storage. This includes the unused offsets below 0Eh. Such a byte returns the last value written to it.
- R4: Seconds advance by one after every `PULSES_PER_SEC` timebase strobes (default 32768). Fewer strobes leave every clock byte unchanged.
- R5: Seconds and minutes count in BCD from 00 to 59. A wrap from 59 to 00 carries into the next byte, so 59 seconds with 09 minutes becomes 00 seconds with 10 minutes.
- R6: When mode bit 1 is 1 (24-hour), hours count 00 to 23. A wrap from 23 to 00 advances the day.
- R7: The last day of a month is 31, or 30 for months 04, 06, 09 and 11. February ends at 28, or at 29 when the BCD year is a multiple of 4. Past the last day, the day becomes 01 and the month advances. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and adds one to the BCD century byte.
- R8: When mode bit 1 is 0 (12-hour), hours hold BCD 01 to 12 in bits 6:0, and bit 7 set means PM. The order is 11 AM (11h), 12 PM (92h), 01 PM (81h). Likewise 11 PM (91h) goes to 12 AM (12h) and advances the day.
- R9: If a host write to a clock byte lands in the same cycle as the once-per-second update, the written value is kept in that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_pulse | input | 1 | One-cycle timebase strobe, synchronous to clk |
| host_port | input | 1 | 0 selects the byte-number port, 1 the value port |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid one clock after the read strobe |

## Verification
A wrong prescale count or a bad carry term shows up at the next read of a clock byte after the second boundary. It appears either as a skipped or missing second, or as a neighbour byte that failed to move. Faulty month-length or leap decoding stays hidden until the day crosses the end of a month, and then shows at once in both the day and the month bytes. A mis-ordered 12-hour flag shows within one second of the 11 to 12 crossing. A lost collision priority appears as an off-by-one in the written byte on the very next read.

// File: rtl/clockram_pkg.sv
package clockram_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] OFS_SEC = 7'h00;
  localparam logic [ADDR_W-1:0] OFS_MIN = 7'h02;
  localparam logic [ADDR_W-1:0] OFS_HR  = 7'h04;
  localparam logic [ADDR_W-1:0] OFS_DAY = 7'h07;
  localparam logic [ADDR_W-1:0] OFS_MON = 7'h08;
  localparam logic [ADDR_W-1:0] OFS_YR  = 7'h09;
  localparam logic [ADDR_W-1:0] OFS_CTL = 7'h0B;
  localparam logic [ADDR_W-1:0] OFS_CEN = 7'h32;

  localparam int unsigned MODE24_BIT = 1;
  localparam int unsigned PM_BIT     = 7;

  typedef struct packed {
    logic [DATA_W-1:0] sec;
    logic [DATA_W-1:0] min;
    logic [DATA_W-1:0] hr;
    logic [DATA_W-1:0] day;
    logic [DATA_W-1:0] mon;
    logic [DATA_W-1:0] yr;
    logic [DATA_W-1:0] ctl;
    logic [DATA_W-1:0] cen;
  } clk_regs_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [3:0] t;
    logic [3:0] o;
    t = yr[7:4];
    o = yr[3:0];
    if (!t[0]) return (o == 4'd0) || (o == 4'd4) || (o == 4'd8);
    else       return (o == 4'd2) || (o == 4'd6);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic is_clock_ofs(input logic [ADDR_W-1:0] a);
    return (a == OFS_SEC) || (a == OFS_MIN) || (a == OFS_HR) || (a == OFS_DAY) ||
           (a == OFS_MON) || (a == OFS_YR) || (a == OFS_CTL) || (a == OFS_CEN);
  endfunction
endpackage

// File: rtl/clockram_prescale.sv
module clockram_prescale #(
  parameter int unsigned PULSES_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tb_pulse,
  output logic sec_tick
);
  localparam int unsigned CNT_W = (PULSES_PER_SEC > 2) ? $clog2(PULSES_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSES_PER_SEC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= 1'b0;
      if (tb_pulse) begin
        if (cnt == LAST) begin
          cnt      <= '0;
          sec_tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: a second only ever follows a timebase strobe
  p_tick_from_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> $past(tb_pulse));
endmodule

// File: rtl/clockram_time.sv
module clockram_time
  import clockram_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  output clk_regs_t         regs
);
  clk_regs_t nxt;
  logic c_min, c_hr, c_day, c_mon, c_yr;
  logic [6:0] h12;

  always_comb begin
    nxt   = regs;
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_yr  = 1'b0;
    h12   = regs.hr[6:0];
    if (sec_tick) begin
      c_min   = (regs.sec == 8'h59);
      nxt.sec = c_min ? 8'h00 : bcd_inc(regs.sec);
      if (c_min) begin
        c_hr    = (regs.min == 8'h59);
        nxt.min = c_hr ? 8'h00 : bcd_inc(regs.min);
      end
      if (c_hr) begin
        if (regs.ctl[MODE24_BIT]) begin
          c_day  = (regs.hr == 8'h23);
          nxt.hr = c_day ? 8'h00 : bcd_inc(regs.hr);
        end else if (h12 == 7'h12) begin
          nxt.hr = {regs.hr[PM_BIT], 7'h01};
        end else if (h12 == 7'h11) begin
          c_day  = regs.hr[PM_BIT];
          nxt.hr = {~regs.hr[PM_BIT], 7'h12};
        end else begin
          nxt.hr = {regs.hr[PM_BIT], 7'(bcd_inc({1'b0, h12}))};
        end
      end
      if (c_day) begin
        c_mon   = (regs.day == month_last(regs.mon, regs.yr));
        nxt.day = c_mon ? 8'h01 : bcd_inc(regs.day);
      end
      if (c_mon) begin
        c_yr    = (regs.mon == 8'h12);
        nxt.mon = c_yr ? 8'h01 : bcd_inc(regs.mon);
      end
      if (c_yr) begin
        if (regs.yr == 8'h99) begin
          nxt.yr  = 8'h00;
          nxt.cen = bcd_inc(regs.cen);
        end else begin
          nxt.yr = bcd_inc(regs.yr);
        end
      end
    end
    if (wr_en) begin
      case (wr_ofs)
        OFS_SEC: nxt.sec = wr_data;
        OFS_MIN: nxt.min = wr_data;
        OFS_HR:  nxt.hr  = wr_data;
        OFS_DAY: nxt.day = wr_data;
        OFS_MON: nxt.mon = wr_data;
        OFS_YR:  nxt.yr  = wr_data;
        OFS_CTL: nxt.ctl = wr_data;
        OFS_CEN: nxt.cen = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '{sec: 8'h00, min: 8'h00, hr: 8'h00, day: 8'h01, mon: 8'h01,
                yr: 8'h00, ctl: 8'h02, cen: 8'h20};
    end else begin
      regs <= nxt;
    end
  end

  // R4: without a second or a host write nothing in the clock moves
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick && !wr_en) |=> $stable(regs));

  // R5: seconds wrap from 59 to 00
  p_sec_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !wr_en && regs.sec == 8'h59) |=> (regs.sec == 8'h00));

  // R6: 23:59:59 in 24-hour mode goes to hour 00 and moves the day
  p_hr_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !wr_en && regs.ctl[MODE24_BIT] && regs.hr == 8'h23 &&
     regs.min == 8'h59 && regs.sec == 8'h59)
    |=> (regs.hr == 8'h00 && regs.day != $past(regs.day)));

  // R8: 11:59:59 AM goes to 12 PM
  p_noon_r8: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !wr_en && !regs.ctl[MODE24_BIT] && regs.hr == 8'h11 &&
     regs.min == 8'h59 && regs.sec == 8'h59) |=> (regs.hr == 8'h92));

  // R9: a host write to seconds is kept even on a second boundary
  p_host_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ofs == OFS_SEC) |=> (regs.sec == $past(wr_data)));
endmodule

// File: rtl/clockram_store.sv
module clockram_store #(
  parameter int unsigned AW    = 7,
  parameter int unsigned DW    = 8,
  parameter int unsigned WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/clockram.sv
module clockram
  import clockram_pkg::*;
#(
  parameter int unsigned PULSES_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tb_pulse,
  input  logic              host_port,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  logic [ADDR_W-1:0] idx;
  logic              sec_tick;
  clk_regs_t         regs;
  logic              data_wr, data_rd, sel_clock;
  logic [DATA_W-1:0] clock_byte, ram_q, hold_q;
  logic              use_ram;

  assign data_wr   = host_wr && host_port;
  assign data_rd   = host_rd && host_port;
  assign sel_clock = is_clock_ofs(idx);

  always_ff @(posedge clk) begin
    if (rst) idx <= '0;
    else if (host_wr && !host_port) idx <= host_wdata[ADDR_W-1:0];
  end

  clockram_prescale #(.PULSES_PER_SEC(PULSES_PER_SEC)) u_prescale (
    .clk(clk), .rst(rst), .tb_pulse(tb_pulse), .sec_tick(sec_tick));

  clockram_time u_time (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .wr_en(data_wr && sel_clock), .wr_ofs(idx), .wr_data(host_wdata),
    .regs(regs));

  clockram_store #(.AW(ADDR_W), .DW(DATA_W), .WORDS(DEPTH)) u_store (
    .clk(clk), .we(data_wr && !sel_clock), .waddr(idx), .wdata(host_wdata),
    .re(data_rd && !sel_clock), .raddr(idx), .rdata(ram_q));

  always_comb begin
    case (idx)
      OFS_SEC: clock_byte = regs.sec;
      OFS_MIN: clock_byte = regs.min;
      OFS_HR:  clock_byte = regs.hr;
      OFS_DAY: clock_byte = regs.day;
      OFS_MON: clock_byte = regs.mon;
      OFS_YR:  clock_byte = regs.yr;
      OFS_CTL: clock_byte = regs.ctl;
      OFS_CEN: clock_byte = regs.cen;
      default: clock_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      use_ram <= 1'b0;
    end else if (host_rd) begin
      if (!host_port) begin
        hold_q  <= {1'b0, idx};
        use_ram <= 1'b0;
      end else if (sel_clock) begin
        hold_q  <= clock_byte;
        use_ram <= 1'b0;
      end else begin
        use_ram <= 1'b1;
      end
    end
  end

  assign host_rdata = use_ram ? ram_q : hold_q;

  // R2: the select port keeps only the low seven bits
  p_index_low7_r2: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_port) |=> (idx == $past(host_wdata[ADDR_W-1:0])));
endmodule

// File: tb/clockram_bench.sv
`timescale 1ns/1ps
module clockram_bench;
  localparam int unsigned PPS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tb_pulse = 1'b0;
  logic       host_port = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;

  always #2 clk = ~clk;

  clockram #(.PULSES_PER_SEC(PPS)) u_clockram (
    .clk(clk), .rst(rst), .tb_pulse(tb_pulse), .host_port(host_port),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata));

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic check_now(input logic [7:0] act, input logic [7:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: each read strobe seen at an edge is compared at the next falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (host_rd) begin
        @(negedge clk);
        if (q.size() == 0) begin
          compared++;
          mismatched++;
          $display("FAIL scoreboard: actual %02h expected none", host_rdata);
        end else begin
          item_t it;
          it = q.pop_front();
          check_now(host_rdata, it.exp, it.tag);
        end
      end
    end
  end

  task automatic wr_sel(input logic [7:0] a);
    @(negedge clk); host_port = 1'b0; host_wr = 1'b1; host_wdata = a;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic wr_val(input logic [7:0] d);
    @(negedge clk); host_port = 1'b1; host_wr = 1'b1; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd_port(input logic p, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    @(negedge clk); host_port = p; host_rd = 1'b1; q.push_back(it);
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    wr_sel(a); wr_val(d);
  endtask

  task automatic peek(input logic [7:0] a, input logic [7:0] exp, input string tag);
    wr_sel(a); rd_port(1'b1, exp, tag);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tb_pulse = 1'b1;
      @(negedge clk); tb_pulse = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    poke(8'h04, h); poke(8'h02, m); poke(8'h00, s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_now(host_rdata, 8'h00, "R1 rdata after reset");
    peek(8'h00, 8'h00, "R1 seconds");
    peek(8'h02, 8'h00, "R1 minutes");
    peek(8'h04, 8'h00, "R1 hours");
    peek(8'h07, 8'h01, "R1 day");
    peek(8'h08, 8'h01, "R1 month");
    peek(8'h09, 8'h00, "R1 year");
    peek(8'h0B, 8'h02, "R1 mode");
    peek(8'h32, 8'h20, "R1 century");

    // R2 select port
    wr_sel(8'hC5);
    rd_port(1'b0, 8'h45, "R2 bit7 dropped");
    wr_sel(8'h7F);
    rd_port(1'b0, 8'h7F, "R2 top index");

    // R3 plain storage, including spare bytes inside the clock area
    poke(8'h40, 8'hA5); poke(8'h7F, 8'h3C); poke(8'h0E, 8'h81); poke(8'h01, 8'h5A);
    poke(8'hC0, 8'h77);
    peek(8'h40, 8'h77, "R3 offset 40h via bit7 alias");
    peek(8'h7F, 8'h3C, "R3 offset 7Fh");
    peek(8'h0E, 8'h81, "R3 offset 0Eh");
    peek(8'h01, 8'h5A, "R3 offset 01h");
    rd_port(1'b1, 8'h5A, "R3 repeated read");
    peek(8'h00, 8'h00, "R3 seconds untouched by storage writes");

    // R4 prescale
    pulses(PPS);
    peek(8'h00, 8'h01, "R4 one second");
    pulses(PPS - 1);
    peek(8'h00, 8'h01, "R4 short of a second");
    pulses(1);
    peek(8'h00, 8'h02, "R4 completed second");

    // R5 minute carry
    set_time(8'h05, 8'h09, 8'h59);
    pulses(PPS);
    peek(8'h00, 8'h00, "R5 seconds wrap");
    peek(8'h02, 8'h10, "R5 minute BCD carry");
    peek(8'h04, 8'h05, "R5 hour unchanged");

    // R6 and R7 full rollover
    poke(8'h07, 8'h31); poke(8'h08, 8'h12); poke(8'h09, 8'h99); poke(8'h32, 8'h20);
    set_time(8'h23, 8'h59, 8'h59);
    pulses(PPS);
    peek(8'h04, 8'h00, "R6 hour wrap");
    peek(8'h02, 8'h00, "R6 minute wrap");
    peek(8'h07, 8'h01, "R7 day wrap");
    peek(8'h08, 8'h01, "R7 month wrap");
    peek(8'h09, 8'h00, "R7 year wrap");
    peek(8'h32, 8'h21, "R7 century step");

    // R7 month lengths
    poke(8'h07, 8'h28); poke(8'h08, 8'h02); poke(8'h09, 8'h23);
    set_time(8'h23, 8'h59, 8'h59);
    pulses(PPS);
    peek(8'h07, 8'h01, "R7 Feb 28 common year");
    peek(8'h08, 8'h03, "R7 to March");
    poke(8'h07, 8'h28); poke(8'h08, 8'h02); poke(8'h09, 8'h24);
    set_time(8'h23, 8'h59, 8'h59);
    pulses(PPS);
    peek(8'h07, 8'h29, "R7 leap Feb 29");
    peek(8'h08, 8'h02, "R7 still February");
    poke(8'h07, 8'h30); poke(8'h08, 8'h04);
    set_time(8'h23, 8'h59, 8'h59);
    pulses(PPS);
    peek(8'h07, 8'h01, "R7 April 30");
    peek(8'h08, 8'h05, "R7 to May");

    // R8 12-hour mode
    poke(8'h0B, 8'h00);
    set_time(8'h11, 8'h59, 8'h59);
    pulses(PPS);
    peek(8'h04, 8'h92, "R8 11 AM to 12 PM");
    set_time(8'h92, 8'h59, 8'h59);
    pulses(PPS);
    peek(8'h04, 8'h81, "R8 12 PM to 01 PM");
    poke(8'h07, 8'h05); poke(8'h08, 8'h03);
    set_time(8'h91, 8'h59, 8'h59);
    pulses(PPS);
    peek(8'h04, 8'h12, "R8 11 PM to 12 AM");
    peek(8'h07, 8'h06, "R8 day advance at midnight");
    poke(8'h0B, 8'h02);

    // R9 collision: host write lands on the edge the second is applied
    set_time(8'h05, 8'h07, 8'h10);
    wr_sel(8'h00);
    for (int i = 0; i < PPS - 1; i++) begin
      @(negedge clk); tb_pulse = 1'b1;
      @(negedge clk); tb_pulse = 1'b0;
    end
    @(negedge clk); tb_pulse = 1'b1;
    @(negedge clk); tb_pulse = 1'b0; host_port = 1'b1; host_wr = 1'b1; host_wdata = 8'h30;
    @(negedge clk); host_wr = 1'b0;
    repeat (2) @(negedge clk);
    peek(8'h00, 8'h30, "R9 host write kept");
    peek(8'h02, 8'h07, "R9 minute unchanged");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL scoreboard: actual %0d left expected 0", q.size());
    end
    finish_run();
  end
endmodule